// File: doc/BRIEF.md
# Memory Self-Test Controller with Retention Holds

This block tests one synchronous single-port SRAM on chip with a fixed march sequence. A 3-bit mode input chooses one of two runs. The pass/fail run stops at the first bad read and reports a sticky failure. The characterisation run keeps going to the end and streams the bit pattern of every bad read out on a 4-bit port, one nibble every two clocks. Each run pauses twice during the first data background so that data retention can be timed. It holds in each pause until an external release input is sampled high.

The memory depth is set by an address-width parameter, which covers arrays up to 64 Kbytes, and the word width is a parameter as well. The march writes all zeros ascending, then reads zeros and writes ones ascending, then reads ones and writes zeros descending, and finally reads zeros ascending. The first pause comes after the all-zero fill and the second after the zero read-back pass. The done, fail and hold outputs leave through one register stage. Right after start-up they give a single one-cycle high pulse so that a pin stuck at either level can be seen.

Top module: `mbist_ctrl`

## Requirements
- R1: When the registered mode is neither 3'b101 (pass/fail run) nor 3'b110 (characterisation run), the controller makes no memory write and holds done_o, fail_o, hold_o and bmap_o low.
- R2: mode_i acts only through a register stage. A change on mode_i between clock edges leaves every output unchanged until the next rising edge.
- R3: After mode_i moves from an invalid code to a valid one ahead of an edge, done_o, fail_o and hold_o read low after the first three edges. All three read high after the fourth edge only, and low again after the fifth.
- R4: A fault-free run enters hold exactly twice. At the first hold every word holds all zeros, and at the second hold every word holds all ones.
- R5: While in hold, hold_o is high, no memory write occurs, and the controller stays in hold until release_i is sampled high on a rising edge.
- R6: In a fault-free run, done_o first reads high 3*DEPTH+2 edges after the edge that samples the second release, and then stays high.
- R7: In the pass/fail run, the first miscompare sets fail_o, which stays high. Memory writes stop, the address stays still and done_o never rises.
- R8: In the characterisation run, a miscompare sets fail_o sticky, but the march still runs to the end, both holds occur and done_o rises.
- R9: In the characterisation run, each failing read sends its miscompare vector (read data XOR expected data) out on bmap_o, least significant nibble first. Each nibble is held for exactly two cycles and the port is zero at all other times. In the pass/fail run bmap_o stays zero.
- R10: Read data is compared one cycle after the read address is issued, so a fault-free memory with one-cycle read latency never reports a miscompare.
- R11: When the registered mode leaves the valid codes, all sticky flags, the bit-map port and the sequence return at once to their cleared state, and memory writes stop.
- R12: While rst_ni is low, all outputs and the memory write enable are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Run select: 101 pass/fail, 110 characterisation, others idle |
| release_i | input | 1 | Ends the current retention hold when sampled high |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the address |
| done_o | output | 1 | Sticky test-complete flag, registered |
| fail_o | output | 1 | Sticky miscompare flag, registered |
| hold_o | output | 1 | Retention hold indicator, registered |
| bmap_o | output | 4 | Half-rate bit-map nibble stream |

## Verification
The hardest state to reach is a characterisation run in which a miscompare lands while the bit-map serialiser is still busy with an earlier record. This requires a fault that fails at more than one march element, so that the stall logic and the record ordering are exercised together. The stimulus table injects stuck-at cells into the bench memory model at chosen addresses and bits. Stuck-at-one cells fail in two separate elements, and stuck-at-zero cells fail only in the descending pass. The bench releases every hold automatically after a few cycles. Separate directed runs stay in hold without a release, check the memory contents at each hold, and measure the done latency counted from the second release.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam logic [2:0] MODE_PROD = 3'b101;
  localparam logic [2:0] MODE_ENG  = 3'b110;

  typedef enum logic [2:0] {
    S_INIT0, S_INIT1, S_INIT2, S_MARCH, S_HOLD, S_DRAIN, S_DONE, S_STOP
  } mbist_st_e;

  typedef enum logic [1:0] {
    E_W0_UP, E_R0W1_UP, E_R1W0_DN, E_R0_UP
  } mbist_elem_e;
endpackage

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mis_o,
  output logic [DATA_W-1:0] vec_o
);
  logic              vld_q;
  logic [DATA_W-1:0] exp_q;

  // one-cycle read latency: compare in the cycle after issue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      exp_q <= '0;
    end else begin
      vld_q <= rd_i;
      if (rd_i) exp_q <= exp_i;
    end
  end

  assign vec_o = rdata_i ^ exp_q;
  assign mis_o = vld_q && (vec_o != '0);
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eng_i,
  input  logic              release_i,
  input  logic              mis_i,
  input  logic              ser_busy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] exp_o,
  output mbist_st_e         st_o
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);

  mbist_st_e   st_q, st_d;
  mbist_elem_e elem_q, elem_d;
  logic        ph_q, ph_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic        act;

  // stall while a miscompare is consumed or the bit-map is draining
  assign act = !mis_i && !ser_busy_i;

  always_comb begin
    st_d    = st_q;
    elem_d  = elem_q;
    ph_d    = ph_q;
    addr_d  = addr_q;
    we_o    = 1'b0;
    rd_o    = 1'b0;
    wdata_o = '0;
    exp_o   = '0;
    unique case (st_q)
      S_INIT0: st_d = S_INIT1;
      S_INIT1: st_d = S_INIT2;
      S_INIT2: st_d = S_MARCH;
      S_MARCH: begin
        if (mis_i && !eng_i) begin
          st_d = S_STOP;
        end else if (act) begin
          unique case (elem_q)
            E_W0_UP: begin
              we_o    = 1'b1;
              wdata_o = '0;
              if (addr_q == ADDR_LAST) begin
                st_d   = S_HOLD;
                elem_d = E_R0W1_UP;
                addr_d = '0;
              end else begin
                addr_d = addr_q + ADDR_ONE;
              end
            end
            E_R0W1_UP: begin
              if (!ph_q) begin
                rd_o  = 1'b1;
                exp_o = '0;
                ph_d  = 1'b1;
              end else begin
                we_o    = 1'b1;
                wdata_o = '1;
                ph_d    = 1'b0;
                if (addr_q == ADDR_LAST) begin
                  st_d   = S_HOLD;
                  elem_d = E_R1W0_DN;
                  addr_d = ADDR_LAST;
                end else begin
                  addr_d = addr_q + ADDR_ONE;
                end
              end
            end
            E_R1W0_DN: begin
              if (!ph_q) begin
                rd_o  = 1'b1;
                exp_o = '1;
                ph_d  = 1'b1;
              end else begin
                we_o    = 1'b1;
                wdata_o = '0;
                ph_d    = 1'b0;
                if (addr_q == '0) begin
                  elem_d = E_R0_UP;
                end else begin
                  addr_d = addr_q - ADDR_ONE;
                end
              end
            end
            E_R0_UP: begin
              rd_o  = 1'b1;
              exp_o = '0;
              if (addr_q == ADDR_LAST) st_d = S_DRAIN;
              else addr_d = addr_q + ADDR_ONE;
            end
            default: ;
          endcase
        end
      end
      S_HOLD:  if (release_i) st_d = S_MARCH;
      S_DRAIN: begin
        if (mis_i && !eng_i) st_d = S_STOP;
        else if (act) st_d = S_DONE;
      end
      S_DONE:  ;
      S_STOP:  ;
      default: st_d = S_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_INIT0;
      elem_q <= E_W0_UP;
      ph_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      elem_q <= elem_d;
      ph_q   <= ph_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;
  assign st_o   = st_q;
endmodule

// File: rtl/mbist_bmap.sv
module mbist_bmap #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] vec_i,
  output logic              busy_o,
  output logic [3:0]        bmap_o
);
  localparam int unsigned NIB = DATA_W / 4;
  localparam int unsigned CW  = $clog2(NIB + 1);

  logic [DATA_W-1:0] sh_q;
  logic [CW-1:0]     left_q;
  logic              ph_q;
  logic [3:0]        out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      ph_q   <= 1'b0;
      out_q  <= '0;
    end else if (load_i) begin
      sh_q   <= vec_i;
      left_q <= CW'(NIB);
      ph_q   <= 1'b0;
    end else if (ph_q) begin
      ph_q <= 1'b0;          // second cycle of the current nibble
    end else if (left_q != '0) begin
      out_q  <= sh_q[3:0];
      sh_q   <= sh_q >> 4;
      left_q <= left_q - CW'(1);
      ph_q   <= 1'b1;
    end else begin
      out_q <= '0;
    end
  end

  assign busy_o = ph_q || (left_q != '0);
  assign bmap_o = out_q;
endmodule

// File: rtl/mbist_flags.sv
module mbist_flags
  import mbist_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  mbist_st_e st_i,
  input  logic      mis_i,
  output logic      done_o,
  output logic      fail_o,
  output logic      hold_o
);
  logic fail_q;
  logic probe;

  assign probe = (st_i == S_INIT1);  // stuck-at pulse on all flags

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      done_o <= 1'b0;
      fail_o <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      fail_q <= fail_q || mis_i;
      done_o <= probe || (st_i == S_DONE);
      fail_o <= probe || fail_q || mis_i;
      hold_o <= probe || (st_i == S_HOLD);
    end
  end
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              release_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              hold_o,
  output logic [3:0]        bmap_o
);
  logic [2:0]        mode_q, mode_prev_q;
  logic              mode_ok, eng_rst_n, is_eng;
  logic              rd, mis, ser_busy;
  logic [DATA_W-1:0] exp_d, mis_vec;
  mbist_st_e         st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 3'b000;
      mode_prev_q <= 3'b000;
    end else begin
      mode_q      <= mode_i;
      mode_prev_q <= mode_q;
    end
  end

  // any invalid or changed mode holds the engine in reset
  assign mode_ok   = ((mode_q == MODE_PROD) || (mode_q == MODE_ENG)) && (mode_q == mode_prev_q);
  assign eng_rst_n = rst_ni && mode_ok;
  assign is_eng    = (mode_q == MODE_ENG);

  mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (eng_rst_n),
    .eng_i      (is_eng),
    .release_i  (release_i),
    .mis_i      (mis),
    .ser_busy_i (ser_busy),
    .addr_o     (mem_addr_o),
    .we_o       (mem_we_o),
    .wdata_o    (mem_wdata_o),
    .rd_o       (rd),
    .exp_o      (exp_d),
    .st_o       (st)
  );

  mbist_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (eng_rst_n),
    .rd_i    (rd),
    .exp_i   (exp_d),
    .rdata_i (mem_rdata_i),
    .mis_o   (mis),
    .vec_o   (mis_vec)
  );

  mbist_bmap #(.DATA_W(DATA_W)) u_bmap (
    .clk_i  (clk_i),
    .rst_ni (eng_rst_n),
    .load_i (mis && is_eng),
    .vec_i  (mis_vec),
    .busy_o (ser_busy),
    .bmap_o (bmap_o)
  );

  mbist_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (eng_rst_n),
    .st_i   (st),
    .mis_i  (mis),
    .done_o (done_o),
    .fail_o (fail_o),
    .hold_o (hold_o)
  );
endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk
  import mbist_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       eng_rst_ni,
  input logic       mode_ok_i,
  input logic       prod_i,
  input mbist_st_e  st_i,
  input logic       release_i,
  input logic       mem_we_o,
  input logic       done_o,
  input logic       fail_o,
  input logic       hold_o,
  input logic [3:0] bmap_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ok_i |-> (!mem_we_o && !done_o && !fail_o && !hold_o && bmap_o == 4'h0));

  assert_hold_no_write_R5: assert property (@(posedge clk_i) disable iff (!eng_rst_ni)
    hold_o |-> !mem_we_o);

  assert_hold_wait_R5: assert property (@(posedge clk_i) disable iff (!eng_rst_ni)
    (st_i == S_HOLD && !release_i) |=> (st_i == S_HOLD));

  assert_done_sticky_R6: assert property (@(posedge clk_i) disable iff (!eng_rst_ni)
    (done_o && $past(done_o)) |=> done_o);

  assert_fail_sticky_R7: assert property (@(posedge clk_i) disable iff (!eng_rst_ni)
    (fail_o && $past(fail_o)) |=> fail_o);

  assert_stop_no_write_R7: assert property (@(posedge clk_i) disable iff (!eng_rst_ni)
    (prod_i && fail_o) |-> !mem_we_o);

  assert_bmap_quiet_prod_R9: assert property (@(posedge clk_i) disable iff (!eng_rst_ni)
    prod_i |-> (bmap_o == 4'h0));

  assert_bmap_half_rate_R9: assert property (@(posedge clk_i) disable iff (!eng_rst_ni)
    (bmap_o != $past(bmap_o)) |=> $stable(bmap_o));
endmodule

bind mbist_ctrl mbist_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eng_rst_ni (eng_rst_n),
  .mode_ok_i  (mode_ok),
  .prod_i     (mode_q == mbist_pkg::MODE_PROD),
  .st_i       (st),
  .release_i  (release_i),
  .mem_we_o   (mem_we_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .hold_o     (hold_o),
  .bmap_o     (bmap_o)
);

// File: tb/mbist_ctrl_tb.sv
`timescale 1ns/1ps
module mbist_ctrl_tb;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    mode_i = 3'b000;
  logic          release_i = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          done_o, fail_o, hold_o;
  logic [3:0]    bmap_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mbist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .release_i(release_i),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .done_o(done_o), .fail_o(fail_o),
    .hold_o(hold_o), .bmap_o(bmap_o)
  );

  // behavioural memory with one injectable stuck-at bit
  logic [DW-1:0] mem [DEPTH];
  logic          f_en = 1'b0;
  logic [AW-1:0] f_addr = '0;
  int            f_bit = 0;
  logic          f_val = 1'b0;

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    logic [DW-1:0] d;
    d = mem[a];
    if (f_en && a == f_addr) d[f_bit] = f_val;
    return d;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= rd_model(mem_addr);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       eng;
    logic       fen;
    logic [3:0] faddr;
    logic [2:0] fbit;
    logic       fval;
    logic       efail;
    logic       edone;
    logic [1:0] eholds;
    logic [3:0] eor;
    logic [3:0] ecyc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 4'd0,  3'd0, 1'b0, 1'b0, 1'b1, 2'd2, 4'h0, 4'd0},
    '{1'b0, 1'b1, 4'd5,  3'd2, 1'b1, 1'b1, 1'b0, 2'd1, 4'h0, 4'd0},
    '{1'b0, 1'b1, 4'd9,  3'd6, 1'b0, 1'b1, 1'b0, 2'd2, 4'h0, 4'd0},
    '{1'b1, 1'b0, 4'd0,  3'd0, 1'b0, 1'b0, 1'b1, 2'd2, 4'h0, 4'd0},
    '{1'b1, 1'b1, 4'd3,  3'd1, 1'b1, 1'b1, 1'b1, 2'd2, 4'h2, 4'd4},
    '{1'b1, 1'b1, 4'd15, 3'd7, 1'b0, 1'b1, 1'b1, 2'd2, 4'h8, 4'd2},
    '{1'b1, 1'b1, 4'd0,  3'd4, 1'b1, 1'b1, 1'b1, 2'd2, 4'h1, 4'd4},
    '{1'b0, 1'b1, 4'd15, 3'd0, 1'b1, 1'b1, 1'b0, 2'd1, 4'h0, 4'd0}
  };

  task automatic run_vec(input vec_t v);
    int holds = 0, hcnt = 0, bcyc = 0;
    logic [3:0] bor = '0;
    logic prev_hold = 1'b0;
    bit term = 0;
    bit we_seen = 0, addr_moved = 0, flag_drop = 0;
    logic [AW-1:0] stop_addr;
    mode_i = 3'b000;
    release_i = 1'b0;
    f_en = v.fen; f_addr = v.faddr; f_bit = int'(v.fbit); f_val = v.fval;
    repeat (3) @(negedge clk);
    mode_i = v.eng ? 3'b110 : 3'b101;
    for (int c = 0; c < 3000 && !term; c++) begin
      @(negedge clk);
      release_i = 1'b0;
      if (c >= 5) begin
        if (hold_o && !prev_hold) holds++;
        if (hold_o) hcnt++; else hcnt = 0;
        if (hcnt == 3) release_i = 1'b1;
        if (bmap_o != 4'h0) begin bor |= bmap_o; bcyc++; end
        if (v.eng ? done_o : (done_o || fail_o)) term = 1;
      end
      prev_hold = hold_o;
    end
    chk("R7 R8 run reached a terminal flag", int'(term), 1);
    stop_addr = mem_addr;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      if (mem_we) we_seen = 1;
      if (mem_addr != stop_addr) addr_moved = 1;
      if (v.edone && !done_o) flag_drop = 1;
      if (v.efail && !fail_o) flag_drop = 1;
      if (bmap_o != 4'h0) begin bor |= bmap_o; bcyc++; end
    end
    chk("R7 R8 R10 fail flag", int'(fail_o), int'(v.efail));
    chk("R6 R7 R8 done flag", int'(done_o), int'(v.edone));
    chk("R4 R8 hold count", holds, int'(v.eholds));
    chk("R9 bit-map nibble value", int'(bor), int'(v.eor));
    chk("R9 bit-map nonzero cycles", bcyc, int'(v.ecyc));
    chk("R6 R7 flags sticky", int'(flag_drop), 0);
    chk("R7 no write after end", int'(we_seen), 0);
    chk("R7 address still after end", int'(addr_moved), 0);
  endtask

  function automatic int mem_mismatch(input logic [DW-1:0] val);
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== val) n++;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seen;
    bit bad;
    // R12: reset state
    mode_i = 3'b101;
    repeat (3) @(negedge clk);
    chk("R12 done in reset", int'(done_o), 0);
    chk("R12 fail in reset", int'(fail_o), 0);
    chk("R12 hold in reset", int'(hold_o), 0);
    chk("R12 bmap in reset", int'(bmap_o), 0);
    chk("R12 we in reset", int'(mem_we), 0);
    mode_i = 3'b000;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // stimulus table
    for (int i = 0; i < 8; i++) run_vec(VECS[i]);

    // R2 and R11: leave the valid codes while fail is sticky
    chk("R7 fail set before clear", int'(fail_o), 1);
    mode_i = 3'b000;
    #1;
    chk("R2 mode change waits for edge", int'(fail_o), 1);
    @(negedge clk);
    chk("R11 fail cleared", int'(fail_o), 0);
    chk("R11 done cleared", int'(done_o), 0);
    chk("R11 hold cleared", int'(hold_o), 0);
    chk("R11 no write after clear", int'(mem_we), 0);
    f_en = 1'b0;

    // R1: invalid codes stay idle
    bad = 0;
    mode_i = 3'b111;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (c == 20) mode_i = 3'b100;
      if (mem_we || done_o || fail_o || hold_o || bmap_o != 4'h0) bad = 1;
    end
    chk("R1 idle on invalid codes", int'(bad), 0);

    // R3: stuck-at probe pulse
    mode_i = 3'b000;
    repeat (3) @(negedge clk);
    mode_i = 3'b101;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R3 done probe", int'(done_o), int'(k == 4));
      chk("R3 fail probe", int'(fail_o), int'(k == 4));
      chk("R3 hold probe", int'(hold_o), int'(k == 4));
    end

    // R4 and R5: first hold, no release
    seen = 0;
    for (int c = 0; c < 100 && !seen; c++) begin
      @(negedge clk);
      if (hold_o) seen = 1;
    end
    chk("R4 first hold reached", seen, 1);
    chk("R4 all zeros at first hold", mem_mismatch('0), 0);
    bad = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (!hold_o || mem_we) bad = 1;
    end
    chk("R5 hold kept without release", int'(bad), 0);
    release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
    @(negedge clk);
    seen = 0;
    for (int c = 0; c < 100 && !seen; c++) begin
      @(negedge clk);
      if (hold_o) seen = 1;
    end
    chk("R4 second hold reached", seen, 1);
    chk("R4 all ones at second hold", mem_mismatch('1), 0);
    repeat (5) @(negedge clk);

    // R6: done latency from the second release
    release_i = 1'b1;
    for (int k = 1; k <= 51; k++) begin
      @(negedge clk);
      if (k == 1) release_i = 1'b0;
      if (k == 50) chk("R6 done low one edge early", int'(done_o), 0);
      if (k == 51) chk("R6 done at 3*DEPTH+2 edges", int'(done_o), 1);
    end
    chk("R10 no miscompare on clean memory", int'(fail_o), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule